// File: doc/BRIEF.md
# Event-Timed Counter Capture Unit

This block runs a wide binary counter off a fixed reference clock and, each time an external event closes, freezes the running count into a holding register. The event input is asynchronous, such as a push button or any other slow physical source. It passes through a synchronizer and a rising-edge qualifier before it is used. Each closure produces exactly one capture. A new capture becomes possible only after the input has been seen low again.

A host watches a level-type ready line. When that line is high, the host reads the held count and pulses an acknowledge input. Two sticky flags report events the host may have missed. One flag means the counter has wrapped since the last acknowledge. The other means a capture overwrote a value that had not yet been acknowledged. A typical use is timing-based entropy gathering, where the count at an unpredictable physical moment is the useful result.

Top module: `evcap_top`

## Requirements
- R1: While `clr_n` is low, the running count is forced to zero. After `clr_n` rises, the count goes up by one on every rising clock edge, so the count just before edge k after release is k-1.
- R2: When `event_in` rises between two clock edges, the capture happens on the third rising edge after that point: two synchronizer stages plus one edge register. The value held is the count from before that edge's increment, which is the count seen just after the event rose plus two.
- R3: One closure gives exactly one capture, however long `event_in` stays high. Once a low level has been sampled, the next rising level captures again.
- R4: `snap_count` holds its value through every cycle that has no capture.
- R5: `snap_ready` goes high on the capture edge and stays high until a `host_ack` is sampled. If a capture and an acknowledge arrive on the same edge, the capture wins.
- R6: The count wraps from all ones to zero with no stall. On the wrap edge `wrap_flag` is set, and a sampled `host_ack` clears it.
- R7: A capture while `snap_ready` is high, with no acknowledge on the same edge, overwrites `snap_count` and sets `overrun_flag`. A sampled `host_ack` clears that flag.
- R8: After reset, `snap_count` is zero and `snap_ready`, `wrap_flag` and `overrun_flag` are all low.
- R9: An `event_in` pulse that lasts only one clock period, and so is sampled high once, still produces a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that drives the counter |
| clr_n | input | 1 | Active-low asynchronous clear for the count and all state |
| event_in | input | 1 | Raw asynchronous event, active high, idles low |
| host_ack | input | 1 | Host acknowledge, sampled on the clock |
| snap_count | output | CNT_W | Held count from the most recent capture |
| snap_ready | output | 1 | A new captured value is waiting |
| wrap_flag | output | 1 | The counter has wrapped since the last acknowledge |
| overrun_flag | output | 1 | An unacknowledged value was overwritten |

## Verification
A capture shows on `snap_count` and `snap_ready` three rising edges after the raw event rises. The bench raises the event just after a falling edge and checks three falling edges later. It predicts the held value as its own edge count at the moment the event rose, plus two. The flags and `snap_ready` react one edge after `host_ack` or the wrap edge, so they are checked at the next falling edge. A narrower counter instance reaches its wrap within the run, and the bench predicts that edge from its edge count since clear.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int DEF_CNT_W  = 24;
  localparam int DEF_STAGES = 2;

  function automatic logic is_rise(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/evcap_sync.sv
module evcap_sync
  import evcap_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = is_rise(prev, level);

  // R3: a qualified edge never repeats on the next cycle
  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/evcap_counter.sv
module evcap_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q,
  output logic         wrap
);
  function automatic logic [W-1:0] next_val(input logic [W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(q);
  end

  assign wrap = (q == '1);

  p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (q == $past(q) + 1'b1));
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (q == '0));
endmodule

// File: rtl/evcap_top.sv
module evcap_top
  import evcap_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int STAGES = DEF_STAGES
) (
  input  logic             clk_ref,
  input  logic             clr_n,
  input  logic             event_in,
  input  logic             host_ack,
  output logic [CNT_W-1:0] snap_count,
  output logic             snap_ready,
  output logic             wrap_flag,
  output logic             overrun_flag
);
  logic [CNT_W-1:0] count;
  logic             wrap_now;
  logic             evt_level;
  logic             cap_fire;
  logic             lost_value;

  evcap_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (clr_n),
    .din   (event_in),
    .level (evt_level),
    .rise  (cap_fire)
  );

  evcap_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk_ref),
    .rst_n (clr_n),
    .q     (count),
    .wrap  (wrap_now)
  );

  assign lost_value = cap_fire & snap_ready & ~host_ack;

  always_ff @(posedge clk_ref or negedge clr_n) begin
    if (!clr_n) begin
      snap_count   <= '0;
      snap_ready   <= 1'b0;
      wrap_flag    <= 1'b0;
      overrun_flag <= 1'b0;
    end else begin
      if (cap_fire) snap_count <= count;
      if (cap_fire)      snap_ready <= 1'b1;
      else if (host_ack) snap_ready <= 1'b0;
      if (wrap_now)      wrap_flag <= 1'b1;
      else if (host_ack) wrap_flag <= 1'b0;
      if (lost_value)    overrun_flag <= 1'b1;
      else if (host_ack) overrun_flag <= 1'b0;
    end
  end

  p_capture_r2: assert property (@(posedge clk_ref) disable iff (!clr_n)
    cap_fire |=> (snap_count == $past(count)));
  p_fire_needs_level_r3: assert property (@(posedge clk_ref) disable iff (!clr_n)
    cap_fire |-> evt_level);
  p_hold_r4: assert property (@(posedge clk_ref) disable iff (!clr_n)
    !cap_fire |=> $stable(snap_count));
  p_ready_r5: assert property (@(posedge clk_ref) disable iff (!clr_n)
    cap_fire |=> snap_ready);
  p_wrap_flag_r6: assert property (@(posedge clk_ref) disable iff (!clr_n)
    wrap_now |=> wrap_flag);
  p_overrun_r7: assert property (@(posedge clk_ref) disable iff (!clr_n)
    lost_value |=> overrun_flag);
endmodule

// File: tb/evcap_top_test.sv
module evcap_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        ack = 1'b0;
  logic        trig_s = 1'b0;
  logic        ack_s = 1'b0;
  logic [23:0] cap;
  logic        rdy, ovf, ovr;
  logic [7:0]  cap_s;
  logic        rdy_s, ovf_s, ovr_s;
  int          cnt_m;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  evcap_top uut (
    .clk_ref(clk), .clr_n(rst_n), .event_in(trig), .host_ack(ack),
    .snap_count(cap), .snap_ready(rdy), .wrap_flag(ovf), .overrun_flag(ovr));

  evcap_top #(.CNT_W(8)) uut_small (
    .clk_ref(clk), .clr_n(rst_n), .event_in(trig_s), .host_ack(ack_s),
    .snap_count(cap_s), .snap_ready(rdy_s), .wrap_flag(ovf_s), .overrun_flag(ovr_s));

  // independent edge count since clear
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_m <= 0;
    else        cnt_m <= cnt_m + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam int VEC_N = 6;
  localparam int HOLD [VEC_N] = '{3, 4, 7, 12, 20, 5};
  localparam int GAP  [VEC_N] = '{3, 9, 4, 15, 6, 30};

  initial begin
    int exp1, exp2;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 snap_count", int'(cap), 0);
    check("R8 ready", int'(rdy), 0);
    check("R8 wrap", int'(ovf), 0);
    check("R8 overrun", int'(ovr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < VEC_N; i++) begin
      trig = 1'b1;
      exp1 = (cnt_m + 2) & 32'hFFFFFF;
      repeat (3) @(negedge clk);
      check("R2 capture value", int'(cap), exp1);
      check("R5 ready set", int'(rdy), 1);
      repeat (HOLD[i] - 3) @(negedge clk);
      trig = 1'b0;
      check("R3 no recapture while held", int'(cap), exp1);
      check("R3 no overrun while held", int'(ovr), 0);
      repeat (3) @(negedge clk);
      check("R4 value held", int'(cap), exp1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      check("R5 ready cleared by ack", int'(rdy), 0);
      repeat (GAP[i]) @(negedge clk);
    end

    // R9 one-period pulse
    trig = 1'b1;
    exp1 = (cnt_m + 2) & 32'hFFFFFF;
    @(negedge clk);
    trig = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 short pulse captured", int'(cap), exp1);
    check("R9 ready", int'(rdy), 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    repeat (4) @(negedge clk);

    // R3 re-arm after one sampled low, R7 overrun on unacked capture
    trig = 1'b1;
    exp1 = (cnt_m + 2) & 32'hFFFFFF;
    repeat (3) @(negedge clk);
    check("R3 first closure", int'(cap), exp1);
    trig = 1'b0;
    @(negedge clk);
    trig = 1'b1;
    exp2 = (cnt_m + 2) & 32'hFFFFFF;
    repeat (3) @(negedge clk);
    check("R3 rearmed capture", int'(cap), exp2);
    check("R7 overrun set", int'(ovr), 1);
    trig = 1'b0;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R7 overrun cleared", int'(ovr), 0);
    check("R5 ready cleared", int'(rdy), 0);
    repeat (4) @(negedge clk);

    // R1 clear on demand, then count restarts from zero
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 clear zeroes holding", int'(cap), 0);
    check("R8 ready after clear", int'(rdy), 0);
    rst_n = 1'b1;
    trig = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 count restarts at zero", int'(cap), 2);
    trig = 1'b0;
    ack = 1'b1; @(negedge clk); ack = 1'b0;

    // R6 wrap on the 8-bit instance
    while (cnt_m < 250) @(negedge clk);
    check("R6 no wrap yet", int'(ovf_s), 0);
    while (cnt_m < 254) @(negedge clk);
    trig_s = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 wrapped to zero", int'(cap_s), 0);
    check("R6 wrap flag set", int'(ovf_s), 1);
    check("R6 wide counter not wrapped", int'(ovf), 0);
    trig_s = 1'b0;
    ack_s = 1'b1; @(negedge clk); ack_s = 1'b0;
    check("R6 wrap flag cleared", int'(ovf_s), 0);
    check("R5 small ready cleared", int'(rdy_s), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule